// File: doc/BRIEF.md
# Block-Ack Transmit Window Tracker

This block keeps track of the frames of one aggregation transmit queue. The frames are numbered by an 8-bit ring sequence. It holds a sliding window of at most 64 consecutive sequence numbers, starting at the read index. For every frame in the window it keeps two status bits: sent and acknowledged. The frame's slot is its sequence number modulo 64. That mapping is unique, because the window never spans more than 64 sequences.

A downstream DMA engine pulls frames through a valid/ready issue port. The tracker offers retransmissions first. A frame can be retransmitted once a block-ack has reported it as not acknowledged, and the one closest to the window base goes first. New frames are offered only while the queue holds unsent frames (the host write index is ahead) and the window has room.

A block-ack carries a start sequence and a 64-bit bitmap. The tracker marks the acknowledged frames and returns the negatively reported frames to the retransmit pool. It then slides the read index over every leading acknowledged frame, clearing those slots as they leave. Because frames are acknowledged out of order, the read index can stall behind a single missing frame while later frames are already acknowledged.

Top module: `baw_tracker`

## Requirements
- R1: After reset, `rd_idx` is 0, `win_space` is 1 (for any `cfg_win` of 1 or more) and no frame is offered while `wr_idx` equals `rd_idx`.
- R2: New frames are offered in increasing sequence order, starting at `rd_idx` plus the number of frames in the window, with `issue_retx` = 0. They are offered while `wr_idx - rd_idx` (mod 256) exceeds that number, and each one is taken on a cycle where `issue_valid` and `issue_ready` are both 1.
- R3: `win_space` is 1 exactly when the window holds fewer than min(`cfg_win`, 64) frames. While it is 0, no new frame is offered.
- R4: Bitmap bit i of a block-ack refers to sequence (`ba_ssn` + i) mod 256. A set bit marks that frame acknowledged.
- R5: Bitmap bits whose sequence is not among the frames already offered in the current window are ignored. So are bits for frames already acknowledged.
- R6: `rd_idx` advances past every leading acknowledged frame of the window, one cycle after the acknowledgements are recorded. It stops at the first frame that is not acknowledged.
- R7: A clear bitmap bit for a sent, unacknowledged frame in the window makes that frame offered again with `issue_retx` = 1 and its own sequence on `issue_seq`.
- R8: Retransmissions are offered before any new frame, the one nearest `rd_idx` first.
- R9: Sequence numbers and `rd_idx` wrap modulo 256 without disturbing ordering or sliding.
- R10: A frame leaving the window has its status cleared. A later frame reusing the same slot starts unsent and unacknowledged, and does not move `rd_idx` until it is itself acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_win | input | 7 | Maximum window size; values above 64 act as 64 |
| wr_idx | input | 8 | Host write index: one past the last queued frame |
| issue_ready | input | 1 | Downstream accepts the offered frame this cycle |
| issue_valid | output | 1 | A frame is offered |
| issue_retx | output | 1 | The offered frame is a retransmission |
| issue_seq | output | 8 | Sequence (ring index) of the offered frame |
| ba_valid | input | 1 | Block-ack present this cycle |
| ba_ssn | input | 8 | Block-ack start sequence |
| ba_bitmap | input | 64 | Block-ack bitmap; bit i covers `ba_ssn` + i |
| rd_idx | output | 8 | Read index: first frame of the window |
| win_space | output | 1 | Another new frame may be requested |

## Verification
The assertions take for granted that `cfg_win` stays fixed while frames are in the window. They also assume `wr_idx` only moves forward and never runs more than 255 sequences ahead of `rd_idx`. The stimulus meets these conditions: it keeps `cfg_win` at 8 for the whole run and raises `wr_idx` only in steps that stay within one window or two of the read index. Its block-acks deliberately include bits that land beyond the offered frames and start sequences far from the window, so that the ignore rule is exercised.

// File: rtl/baw_pkg.sv
package baw_pkg;
    localparam int SEQ_W   = 8;
    localparam int WIN_MAX = 64;
    localparam int SLOT_W  = $clog2(WIN_MAX);
    localparam int CNT_W   = SLOT_W + 1;

    typedef logic [SEQ_W-1:0]   seq_t;
    typedef logic [SLOT_W-1:0]  slot_t;
    typedef logic [CNT_W-1:0]   cnt_t;
    typedef logic [WIN_MAX-1:0] flags_t;

    typedef struct packed {
        logic valid;
        logic retx;
        seq_t seq;
    } issue_t;

    // Slot of a sequence inside the status arrays
    function automatic slot_t slot_of(seq_t s);
        return s[SLOT_W-1:0];
    endfunction

    // True when s lies among the n frames starting at base
    function automatic logic in_window(seq_t s, seq_t base, cnt_t n);
        seq_t off;
        off = s - base;
        return off < seq_t'(n);
    endfunction
endpackage

// File: rtl/baw_ba_update.sv
module baw_ba_update
    import baw_pkg::*;
(
    input  logic   ba_valid,
    input  seq_t   ba_ssn,
    input  flags_t ba_bitmap,
    input  seq_t   base,
    input  cnt_t   n_sent,
    input  flags_t sent_q,
    input  flags_t acked_q,
    output flags_t ack_set,
    output flags_t sent_clr
);
    always_comb begin
        seq_t  s;
        slot_t sl;
        s        = '0;
        sl       = '0;
        ack_set  = '0;
        sent_clr = '0;
        for (int i = 0; i < WIN_MAX; i++) begin
            s  = ba_ssn + seq_t'(i);
            sl = slot_of(s);
            if (ba_valid && in_window(s, base, n_sent) && !acked_q[sl]) begin
                if (ba_bitmap[i])
                    ack_set[sl] = 1'b1;
                else if (sent_q[sl])
                    sent_clr[sl] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/baw_lead_count.sv
module baw_lead_count
    import baw_pkg::*;
(
    input  seq_t   base,
    input  cnt_t   n_sent,
    input  flags_t acked_q,
    output cnt_t   lead
);
    always_comb begin
        logic run;
        run  = 1'b1;
        lead = '0;
        for (int k = 0; k < WIN_MAX; k++) begin
            if (run && (k < int'(n_sent)) && acked_q[slot_of(base + seq_t'(k))])
                lead = cnt_t'(k + 1);
            else
                run = 1'b0;
        end
    end
endmodule

// File: rtl/baw_issue_arb.sv
module baw_issue_arb
    import baw_pkg::*;
(
    input  seq_t   base,
    input  cnt_t   n_sent,
    input  flags_t sent_q,
    input  flags_t acked_q,
    input  seq_t   wr_idx,
    input  cnt_t   eff_win,
    output issue_t cand,
    output logic   space
);
    logic found;
    seq_t koff;
    seq_t queued;
    logic new_ok;

    // Downward scan so the offset nearest the base wins
    always_comb begin
        found = 1'b0;
        koff  = '0;
        for (int k = WIN_MAX - 1; k >= 0; k--) begin
            if ((k < int'(n_sent)) && !sent_q[slot_of(base + seq_t'(k))]
                && !acked_q[slot_of(base + seq_t'(k))]) begin
                found = 1'b1;
                koff  = seq_t'(k);
            end
        end
    end

    always_comb begin
        queued     = wr_idx - base;
        space      = n_sent < eff_win;
        new_ok     = space && (queued > seq_t'(n_sent));
        cand.valid = found || new_ok;
        cand.retx  = found;
        cand.seq   = found ? (base + koff) : (base + seq_t'(n_sent));
    end
endmodule

// File: rtl/baw_tracker.sv
module baw_tracker
    import baw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   cfg_win,
    input  logic [SEQ_W-1:0]   wr_idx,
    input  logic               issue_ready,
    output logic               issue_valid,
    output logic               issue_retx,
    output logic [SEQ_W-1:0]   issue_seq,
    input  logic               ba_valid,
    input  logic [SEQ_W-1:0]   ba_ssn,
    input  logic [WIN_MAX-1:0] ba_bitmap,
    output logic [SEQ_W-1:0]   rd_idx,
    output logic               win_space
);
    seq_t   base_q, base_d;
    cnt_t   nsent_q, nsent_d;
    flags_t sent_q, sent_d;
    flags_t acked_q, acked_d;

    cnt_t   eff_win;
    cnt_t   lead;
    flags_t ack_set, sent_clr, leave;
    issue_t cand;
    logic   fire;

    assign eff_win = (cfg_win > cnt_t'(WIN_MAX)) ? cnt_t'(WIN_MAX) : cfg_win;

    baw_ba_update u_ba (
        .ba_valid (ba_valid),
        .ba_ssn   (ba_ssn),
        .ba_bitmap(ba_bitmap),
        .base     (base_q),
        .n_sent   (nsent_q),
        .sent_q   (sent_q),
        .acked_q  (acked_q),
        .ack_set  (ack_set),
        .sent_clr (sent_clr)
    );

    baw_lead_count u_lead (
        .base   (base_q),
        .n_sent (nsent_q),
        .acked_q(acked_q),
        .lead   (lead)
    );

    baw_issue_arb u_arb (
        .base   (base_q),
        .n_sent (nsent_q),
        .sent_q (sent_q),
        .acked_q(acked_q),
        .wr_idx (wr_idx),
        .eff_win(eff_win),
        .cand   (cand),
        .space  (win_space)
    );

    assign issue_valid = cand.valid;
    assign issue_retx  = cand.retx;
    assign issue_seq   = cand.seq;
    assign rd_idx      = base_q;
    assign fire        = cand.valid && issue_ready;

    always_comb begin
        leave = '0;
        for (int k = 0; k < WIN_MAX; k++) begin
            if (k < int'(lead))
                leave[slot_of(base_q + seq_t'(k))] = 1'b1;
        end
        sent_d = sent_q & ~sent_clr;
        if (fire)
            sent_d[slot_of(cand.seq)] = 1'b1;
        sent_d  = sent_d & ~leave;
        acked_d = (acked_q | ack_set) & ~leave;
        nsent_d = nsent_q - lead + cnt_t'(fire && !cand.retx);
        base_d  = base_q + seq_t'(lead);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            nsent_q <= '0;
            sent_q  <= '0;
            acked_q <= '0;
        end else begin
            base_q  <= base_d;
            nsent_q <= nsent_d;
            sent_q  <= sent_d;
            acked_q <= acked_d;
        end
    end

    AST_NSENT_MAX: assert property (@(posedge clk) disable iff (rst)
        nsent_q <= cnt_t'(WIN_MAX)); // R3
    AST_RD_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> seq_t'(rd_idx - $past(rd_idx)) <= seq_t'($past(nsent_q))); // R6
    AST_RD_HOLD_UNACKED: assert property (@(posedge clk) disable iff (rst)
        !acked_q[slot_of(rd_idx)] |=> rd_idx == $past(rd_idx)); // R6
    AST_RETX_INSIDE: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_retx) |-> in_window(issue_seq, rd_idx, nsent_q)); // R7
endmodule

// File: tb/tb_baw_tracker.sv
`timescale 1ns/1ps
module tb_baw_tracker;
    logic        clk = 1'b0;
    logic        rst;
    logic [6:0]  cfg_win;
    logic [7:0]  wr_idx;
    logic        issue_ready;
    logic        issue_valid;
    logic        issue_retx;
    logic [7:0]  issue_seq;
    logic        ba_valid;
    logic [7:0]  ba_ssn;
    logic [63:0] ba_bitmap;
    logic [7:0]  rd_idx;
    logic        win_space;

    int n_chk  = 0;
    int n_fail = 0;
    logic [8:0] exp_q[$];
    logic [7:0] exp_rd;

    always #2.5 clk = ~clk;

    baw_tracker dut (
        .clk(clk), .rst(rst), .cfg_win(cfg_win), .wr_idx(wr_idx),
        .issue_ready(issue_ready), .issue_valid(issue_valid),
        .issue_retx(issue_retx), .issue_seq(issue_seq),
        .ba_valid(ba_valid), .ba_ssn(ba_ssn), .ba_bitmap(ba_bitmap),
        .rd_idx(rd_idx), .win_space(win_space)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] seq, input logic retx);
        exp_q.push_back({retx, seq});
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_ba(input logic [7:0] ssn, input logic [63:0] bm);
        ba_ssn    = ssn;
        ba_bitmap = bm;
        ba_valid  = 1'b1;
        wait_cyc(1);
        ba_valid  = 1'b0;
        ba_bitmap = '0;
    endtask

    // Scoreboard monitor: compares each accepted frame with the expected queue
    always @(negedge clk) begin
        if (!rst && issue_valid && issue_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected issue seq", int'(issue_seq), -1);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                if (e[8])
                    chk({issue_retx, issue_seq} == e, "R7/R8 retransmit order",
                        int'({issue_retx, issue_seq}), int'(e));
                else
                    chk({issue_retx, issue_seq} == e, "R2 new frame order",
                        int'({issue_retx, issue_seq}), int'(e));
            end
        end
    end

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_win = 7'd8; wr_idx = 8'd0; issue_ready = 1'b1;
        ba_valid = 1'b0; ba_ssn = '0; ba_bitmap = '0;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        // R1 reset state
        chk(rd_idx == 8'd0, "R1 rd_idx after reset", int'(rd_idx), 0);
        chk(win_space == 1'b1, "R1 win_space after reset", int'(win_space), 1);
        chk(issue_valid == 1'b0, "R1 idle when queue empty", int'(issue_valid), 0);

        // R2 new frames in order, limited by host write index
        for (int s = 0; s < 5; s++) push(8'(s), 1'b0);
        wr_idx = 8'd5;
        wait_cyc(10);
        chk(exp_q.size() == 0, "R2 all queued frames issued", exp_q.size(), 0);
        chk(issue_valid == 1'b0, "R2 stops at write index", int'(issue_valid), 0);

        // R3 window fills to cfg_win
        for (int s = 5; s < 8; s++) push(8'(s), 1'b0);
        wr_idx = 8'd20;
        wait_cyc(10);
        chk(exp_q.size() == 0, "R3 fill to window size", exp_q.size(), 0);
        chk(win_space == 1'b0, "R3 win_space when full", int'(win_space), 0);
        chk(issue_valid == 1'b0, "R3 no new frame when full", int'(issue_valid), 0);

        // R4 R6 R7 R8: acks 0,1,3,4,6,7; 2 and 5 missing; bit 20 outside window (R5)
        push(8'd2, 1'b1); push(8'd5, 1'b1); push(8'd8, 1'b0); push(8'd9, 1'b0);
        send_ba(8'd0, 64'h0000_0000_0010_00DB);
        wait_cyc(10);
        chk(exp_q.size() == 0, "R8 retransmits then new", exp_q.size(), 0);
        chk(rd_idx == 8'd2, "R6 slide stops at first missing", int'(rd_idx), 2);
        chk(win_space == 1'b0, "R3 refilled window", int'(win_space), 0);

        // R5 block-ack entirely outside the window is ignored
        send_ba(8'd100, '1);
        wait_cyc(5);
        chk(rd_idx == 8'd2, "R5 out-of-window ack ignored", int'(rd_idx), 2);
        chk(issue_valid == 1'b0, "R5 no frame released", int'(issue_valid), 0);

        // R4 offset start sequence acks 2..9, window moves to 10
        for (int s = 10; s < 18; s++) push(8'(s), 1'b0);
        send_ba(8'd2, '1);
        wait_cyc(15);
        chk(rd_idx == 8'd10, "R4 ack with offset start", int'(rd_idx), 10);
        chk(exp_q.size() == 0, "R6 freed space refilled", exp_q.size(), 0);
        chk(win_space == 1'b0, "R3 full after refill", int'(win_space), 0);

        // R9 R10: many rounds, wrap past 256 and reuse every slot
        exp_rd = 8'd10;
        for (int r = 0; r < 32; r++) begin
            chk(rd_idx == exp_rd, "R10 no stale ack on reused slot",
                int'(rd_idx), int'(exp_rd));
            for (int s = 8; s < 16; s++) push(exp_rd + 8'(s), 1'b0);
            wr_idx = exp_rd + 8'd16;
            send_ba(exp_rd, 64'h0000_0000_0000_00FF);
            exp_rd = exp_rd + 8'd8;
            wait_cyc(15);
            chk(rd_idx == exp_rd, "R9 read index wraps", int'(rd_idx), int'(exp_rd));
            chk(exp_q.size() == 0, "R9 issue order across wrap", exp_q.size(), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule